// File: doc/BRIEF.md
# Row-Buffered Sprite Attribute Memory

This block holds 256 bytes of sprite attributes: 64 entries of 4 bytes, entry n at bytes 4n to 4n+3. The storage is arranged as 32 rows of 8 bytes. The storage array is only ever read or written a whole row at a time. The CPU side has two write strobes. One loads the byte address. The other stores a byte at that address and then steps the address. Every byte store becomes a three-step row operation: fetch the row into a single 8-byte row buffer, patch one byte of the buffer, then commit the buffer back to the row. A sequencer runs these steps back to back, so nothing else touches the array in between.

Changing the address is also a row operation, and a mode input picks its behaviour. In clean mode, the buffer is committed to the row of the old address and then the row of the new address is fetched. In legacy mode, the row named by an open-bus value is fetched and committed into the row of the new address. This copies stale sprite data into the new row, as some older parts do. A combinational read port serves the renderer. It reads the array when the sequencer is idle. While the sequencer is busy, it reads the row buffer if the buffer holds the requested row, and otherwise reports that no data is available.

Top module: `sprite_row_mem`

## Requirements
- R1: The byte at address A is in row A[7:3], column A[2:0]. A byte stored at A is returned by the read port at A, and bytes 4n..4n+3 form entry n.
- R2: A data store uses the current address and then increments it by one, wrapping from 0xFF to 0x00.
- R3: A data store accepted on a clock edge keeps `busy` high for exactly 3 cycles (fetch, patch, commit). The other 7 bytes of the row keep their values.
- R4: An access that arrives while busy is held in a one-deep pending slot and runs after the current sequence. Two stores to one row issued back to back give the same contents as the same two stores issued separately.
- R5: In clean mode (`quirkMode`=0), an address write commits the buffer to the old row, fetches the new row and sets the address. Memory contents are unchanged.
- R6: In legacy mode (`quirkMode`=1), an address write copies all 8 bytes of row `openBus[7:3]` into row `cpuData[7:3]` and sets the address to `cpuData`.
- R7: While idle, `rdValid`=1 and `rdData` is the stored byte. While busy, `rdValid`=1 only when the buffer is valid and holds row `rdAddr[7:3]`, and then `rdData` is the buffered byte. Otherwise `rdValid`=0.
- R8: Reset sets the address to 0, marks the buffer invalid and leaves the sequencer idle. The first data store after reset lands at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| quirkMode | input | 1 | 1 = legacy row copy on an address write |
| openBus | input | 8 | Open-bus value; bits 7:3 pick the source row in legacy mode |
| cpuAddrWr | input | 1 | One-cycle strobe: load the address from cpuData |
| cpuDataWr | input | 1 | One-cycle strobe: store cpuData at the address and increment |
| cpuData | input | 8 | CPU write data |
| busy | output | 1 | A sequence is running or one is pending |
| rdAddr | input | 8 | Render read address |
| rdData | output | 8 | Render read data, 0 when not valid |
| rdValid | output | 1 | rdData holds the requested byte |

## Verification
The assertions assume that the CPU never raises both strobes in the same cycle, and never raises a strobe while a request is already pending, since a third access would be dropped. The stimulus waits for `busy` to fall between operations and issues at most one follow-up access during a sequence, so the pending slot is used but never overrun. The legacy-mode copy and the wrap of the address are checked against a byte-level model of the memory.

// File: rtl/sprite_row_pkg.sv
package sprite_row_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int COL_W     = 3;
  localparam int ROW_W     = ADDR_W - COL_W;
  localparam int ROW_BYTES = 1 << COL_W;
  localparam int ROWS      = 1 << ROW_W;
  localparam int ROW_BITS  = ROW_BYTES * DATA_W;

  typedef enum logic [1:0] {OP_DATA, OP_ADDR_FIX, OP_ADDR_QUIRK} opKind_t;

  typedef struct packed {
    opKind_t             kind;
    logic [DATA_W-1:0]   data;
    logic [ROW_W-1:0]    obRow;
  } opRec_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic                load;
    logic [ROW_W-1:0]    loadRow;
    logic                modify;
    logic                writeback;
    logic                useBufRow;
    logic                setAddr;
    logic                incAddr;
    logic [DATA_W-1:0]   data;
  } seqStrobe_t;
endpackage

// File: rtl/sprite_row_dp.sv
module sprite_row_dp
  import sprite_row_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] addrQ,
  output logic              bufValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [ROW_BITS-1:0] mem [ROWS];
  logic [ROW_BITS-1:0] rowBuf;
  logic [ROW_W-1:0]    bufRow;
  logic [ROW_W-1:0]    wbRow;
  logic [ROW_W-1:0]    rdRow;
  logic [COL_W-1:0]    rdCol;
  logic [COL_W-1:0]    addrCol;

  assign wbRow   = stb.useBufRow ? bufRow : addrQ[ADDR_W-1:COL_W];
  assign rdRow   = rdAddr[ADDR_W-1:COL_W];
  assign rdCol   = rdAddr[COL_W-1:0];
  assign addrCol = addrQ[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (stb.writeback) mem[wbRow] <= rowBuf;
  end

  always_ff @(posedge clk) begin
    if (stb.load)        rowBuf <= mem[stb.loadRow];
    else if (stb.modify) rowBuf[addrCol*DATA_W +: DATA_W] <= stb.data;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      bufValid <= 1'b0;
      bufRow   <= '0;
    end else begin
      if (stb.setAddr)      addrQ <= stb.data;
      else if (stb.incAddr) addrQ <= addrQ + 1'b1;
      if (stb.load) begin
        bufValid <= 1'b1;
        bufRow   <= stb.loadRow;
      end
    end
  end

  always_comb begin
    rdData  = '0;
    rdValid = 1'b0;
    if (!busy) begin
      rdValid = 1'b1;
      rdData  = mem[rdRow][rdCol*DATA_W +: DATA_W];
    end else if (bufValid && bufRow == rdRow) begin
      rdValid = 1'b1;
      rdData  = rowBuf[rdCol*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/sprite_row_ctl.sv
module sprite_row_ctl
  import sprite_row_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              quirkMode,
  input  logic [ADDR_W-1:0] openBus,
  input  logic              cpuAddrWr,
  input  logic              cpuDataWr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic [ADDR_W-1:0] addrQ,
  input  logic              bufValid,
  output seqStrobe_t        stb,
  output logic              busy,
  output logic              pendFull
);
  typedef enum logic [1:0] {ST_IDLE, ST_ONE, ST_TWO, ST_THREE} seqState_t;

  seqState_t state;
  opRec_t    cur, pend, req;
  logic      reqValid, lastStep;

  assign reqValid = cpuAddrWr | cpuDataWr;
  always_comb begin
    req.kind  = cpuAddrWr ? (quirkMode ? OP_ADDR_QUIRK : OP_ADDR_FIX) : OP_DATA;
    req.data  = cpuData;
    req.obRow = openBus[ADDR_W-1:COL_W];
  end

  assign lastStep = (cur.kind == OP_DATA) ? (state == ST_THREE) : (state == ST_TWO);
  assign busy     = (state != ST_IDLE) | pendFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendFull <= 1'b0;
      cur      <= '0;
      pend     <= '0;
    end else if (state == ST_IDLE) begin
      if (pendFull) begin
        cur      <= pend;
        state    <= ST_ONE;
        pendFull <= reqValid;
        if (reqValid) pend <= req;
      end else if (reqValid) begin
        cur   <= req;
        state <= ST_ONE;
      end
    end else begin
      if (lastStep && pendFull) begin
        cur      <= pend;
        state    <= ST_ONE;
        pendFull <= reqValid;
        if (reqValid) pend <= req;
      end else begin
        if (reqValid) begin
          pend     <= req;
          pendFull <= 1'b1;
        end
        if (lastStep)              state <= ST_IDLE;
        else if (state == ST_ONE)  state <= ST_TWO;
        else                       state <= ST_THREE;
      end
    end
  end

  always_comb begin
    stb      = '0;
    stb.data = cur.data;
    unique case (cur.kind)
      OP_DATA: begin
        if (state == ST_ONE) begin
          stb.load    = 1'b1;
          stb.loadRow = addrQ[ADDR_W-1:COL_W];
        end
        if (state == ST_TWO) stb.modify = 1'b1;
        if (state == ST_THREE) begin
          stb.writeback = 1'b1;
          stb.incAddr   = 1'b1;
        end
      end
      OP_ADDR_FIX: begin
        if (state == ST_ONE) begin
          stb.writeback = bufValid;
          stb.useBufRow = 1'b1;
          stb.setAddr   = 1'b1;
        end
        if (state == ST_TWO) begin
          stb.load    = 1'b1;
          stb.loadRow = addrQ[ADDR_W-1:COL_W];
        end
      end
      default: begin
        if (state == ST_ONE) begin
          stb.load    = 1'b1;
          stb.loadRow = cur.obRow;
          stb.setAddr = 1'b1;
        end
        if (state == ST_TWO) stb.writeback = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sprite_row_mem.sv
module sprite_row_mem
  import sprite_row_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              quirkMode,
  input  logic [ADDR_W-1:0] openBus,
  input  logic              cpuAddrWr,
  input  logic              cpuDataWr,
  input  logic [DATA_W-1:0] cpuData,
  output logic              busy,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  seqStrobe_t        stb;
  logic [ADDR_W-1:0] addrQ;
  logic              bufValid;
  logic              pendFull;

  sprite_row_ctl ctl_i (
    .clk(clk), .rstN(rstN), .quirkMode(quirkMode), .openBus(openBus),
    .cpuAddrWr(cpuAddrWr), .cpuDataWr(cpuDataWr), .cpuData(cpuData),
    .addrQ(addrQ), .bufValid(bufValid), .stb(stb), .busy(busy),
    .pendFull(pendFull)
  );

  sprite_row_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .rdAddr(rdAddr),
    .addrQ(addrQ), .bufValid(bufValid), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/sprite_row_chk.sv
module sprite_row_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       cpuAddrWr,
  input logic       cpuDataWr,
  input logic       rdValid,
  input logic [7:0] addrQ,
  input logic       bufValid,
  input logic       incAddr,
  input logic       pendFull
);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    pendFull |-> !(cpuAddrWr || cpuDataWr));

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuAddrWr && cpuDataWr));

  p_access_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddrWr || cpuDataWr) |=> busy);

  p_idle_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> rdValid);

  p_addr_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    incAddr |=> addrQ == 8'($past(addrQ) + 8'd1));

  p_seq_two_steps_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

  p_reset_state_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (addrQ == 8'd0 && !bufValid && !busy));
endmodule

bind sprite_row_mem sprite_row_chk chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .cpuAddrWr(cpuAddrWr),
  .cpuDataWr(cpuDataWr), .rdValid(rdValid), .addrQ(addrQ),
  .bufValid(bufValid), .incAddr(stb.incAddr), .pendFull(pendFull)
);

// File: tb/sprite_row_mem_tb.sv
module sprite_row_mem_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       quirkMode = 1'b0;
  logic [7:0] openBus = 8'h20;
  logic       cpuAddrWr = 1'b0;
  logic       cpuDataWr = 1'b0;
  logic [7:0] cpuData = 8'h00;
  logic       busy;
  logic [7:0] rdAddr = 8'h00;
  logic [7:0] rdData;
  logic       rdValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] refMem [256];
  logic [7:0] refAddr;

  always #4 clk = ~clk;

  sprite_row_mem dut_i (
    .clk(clk), .rstN(rstN), .quirkMode(quirkMode), .openBus(openBus),
    .cpuAddrWr(cpuAddrWr), .cpuDataWr(cpuDataWr), .cpuData(cpuData),
    .busy(busy), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void modelOp(input bit isAddr, input bit q, input logic [7:0] d);
    if (!isAddr) begin
      refMem[refAddr] = d;
      refAddr = refAddr + 8'd1;
    end else begin
      if (q)
        for (int i = 0; i < 8; i++)
          refMem[{d[7:3], 3'(i)}] = refMem[{openBus[7:3], 3'(i)}];
      refAddr = d;
    end
  endfunction

  // called at a negedge; returns at the next negedge with strobes low
  task automatic issueOp(input bit isAddr, input bit q, input logic [7:0] d);
    quirkMode = q; cpuAddrWr = isAddr; cpuDataWr = !isAddr; cpuData = d;
    modelOp(isAddr, q, d);
    @(negedge clk);
    cpuAddrWr = 1'b0; cpuDataWr = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic compareAll(input string tag);
    for (int a = 0; a < 256; a++) begin
      rdAddr = 8'(a);
      #1;
      check({tag, " rdValid"}, 32'(rdValid), 32'd1);
      check({tag, " byte"}, {24'd0, rdData}, {24'd0, refMem[a]});
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    refAddr = 8'h00;
    for (int a = 0; a < 256; a++) refMem[a] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: idle after reset
    check("R8 busy after reset", 32'(busy), 32'd0);

    // R8 R2 R1: fill all 256 bytes from reset address, wraps back to 0
    for (int i = 0; i < 256; i++) begin
      issueOp(1'b0, 1'b0, 8'(i * 37 + 5));
      waitIdle();
    end
    compareAll("R1 R8 fill");
    // R2: after 256 stores the address is back at 0: next store hits byte 0
    issueOp(1'b0, 1'b0, 8'hA5);
    waitIdle();
    rdAddr = 8'h00; #1;
    check("R2 wrap store at 0", {24'd0, rdData}, 32'hA5);

    // R3: busy exactly three cycles, neighbours preserved
    issueOp(1'b1, 1'b0, 8'h09);
    waitIdle();
    issueOp(1'b0, 1'b0, 8'h11);
    check("R3 busy c1", 32'(busy), 32'd1);
    @(negedge clk);
    check("R3 busy c2", 32'(busy), 32'd1);
    // R7: buffer holds row 1 during the sequence
    rdAddr = 8'h0C; #1;
    check("R7 buffered valid", 32'(rdValid), 32'd1);
    check("R7 buffered data", {24'd0, rdData}, {24'd0, refMem[8'h0C]});
    rdAddr = 8'h40; #1;
    check("R7 other row invalid", 32'(rdValid), 32'd0);
    @(negedge clk);
    check("R3 busy c3", 32'(busy), 32'd1);
    rdAddr = 8'h09; #1;
    check("R7 patched byte", {24'd0, rdData}, 32'h11);
    @(negedge clk);
    check("R3 busy end", 32'(busy), 32'd0);
    // R4: back-to-back store to byte 10 via pending slot
    issueOp(1'b0, 1'b0, 8'h22);
    issueOp(1'b0, 1'b0, 8'h33);
    waitIdle();
    compareAll("R3 R4 same row");

    // R5: clean address change leaves memory alone
    issueOp(1'b1, 1'b0, 8'h77);
    waitIdle();
    compareAll("R5 clean addr");

    // R6: legacy mode copies row 4 (0x20) into row 10 (0x53)
    openBus = 8'h20;
    issueOp(1'b1, 1'b1, 8'h53);
    waitIdle();
    compareAll("R6 quirk copy");
    issueOp(1'b0, 1'b0, 8'hEE);
    waitIdle();
    rdAddr = 8'h53; #1;
    check("R6 addr set", {24'd0, rdData}, 32'hEE);

    // R4 R5 R6 R2: random mix, sometimes a second access while busy
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      openBus = 8'($urandom);
      issueOp(r[3:0] == 4'd0, r[4], 8'(r[15:8]));
      if (r[20:18] == 3'd0) issueOp(r[21] && r[22], r[23], 8'(r[31:24]));
      waitIdle();
    end
    compareAll("R4 R6 random");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule